// File: doc/BRIEF.md
# Supply Brown-Out Warning and Reset Sequencer

This block is the digital side of a supply monitor that uses two thresholds. Two comparator outputs arrive as asynchronous levels: one is high while the supply sits above the upper threshold, the other while it sits above the lower threshold. The block first passes each of them through a synchronizer and a hold-time filter. A small sequencer then decides when the chip should be held in reset and when firmware should be warned.

Sinking under the upper threshold gives firmware one interrupt pulse, so that it can save state. Only sinking under the lower threshold pulls the internal reset. After a warning, the supply may bounce back above the upper threshold and fall again without a second interrupt. The sequencer re-arms only after it has passed through a low-voltage reset. At power-up the reset stays asserted until the supply is filtered above both thresholds. Every release of reset is stretched by a programmable number of clocks.

A two-bit mode word is captured while the system reset is high. Only the encoding 2'b10 enables the combined warning-and-reset behaviour. Two byte-wide registers are reachable through a simple write strobe and a registered read port.

Top module: `lvd_supervisor`

## Requirements
- R1: `mode_sel` is captured only while `rst` is high. Changes to it after reset have no effect, and the sequencer is active only when the captured value is 2'b10.
- R2: From reset, `lvd_rst_req` stays high for as long as the filtered supply is not above the upper threshold. Power-up releases it only once both comparator inputs read high.
- R3: Once the release condition is seen, `lvd_rst_req` stays high for at least RST_HOLD more clocks. With both inputs raised on one clock edge, it falls on the (FILT_CYCLES+RST_HOLD+4)-th rising edge, counting that edge as the first.
- R4: During normal operation, a fall of `vdd_above_hi` with `vdd_above_lo` still high gives exactly one single-cycle `lvd_irq` pulse on the (FILT_CYCLES+3)-th rising edge, and leaves `lvd_rst_req` low.
- R5: After a warning, no further `lvd_irq` is issued while `vdd_above_lo` stays high, however often `vdd_above_hi` recovers and falls again.
- R6: A fall of `vdd_above_lo` in normal or warned operation raises `lvd_rst_req` on the (FILT_CYCLES+4)-th rising edge. The reset is released only when both inputs read high, and the sequencer is re-armed so that the next upper-threshold fall warns again.
- R7: A comparator level that holds for fewer than FILT_CYCLES clocks after the two synchronizer stages has no effect on either output.
- R8: After reset, both registers read 0x00. In the level register (address 1), bit 7 = 0 selects interrupt mode and bit 0 = 0 selects the high threshold.
- R9: Bit 7 of the control register (address 0) is the write enable of the level register. While it is 0, writes to address 1 are ignored. While it is 1, bits 7 and 0 are stored and the other bits read 0.
- R10: Bit 0 of the control register is a sticky flag. Each `lvd_irq` pulse sets it. Writing 1 to that bit clears it, writing 0 leaves it unchanged, and a set in the same cycle wins over a clear.
- R11: With a captured mode other than 2'b10, `lvd_irq` never pulses, and `lvd_rst_req` falls on the (RST_HOLD+2)-th rising edge after `rst` is released, whatever the comparator inputs do.
- R12: `reg_rdata` shows the register selected by `reg_addr` one clock after that address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset; also the power-on window for capturing the mode word |
| mode_sel | input | 2 | Operating mode, captured during reset; 2'b10 selects warning-and-reset operation |
| vdd_above_hi | input | 1 | Asynchronous level: supply above the upper threshold |
| vdd_above_lo | input | 1 | Asynchronous level: supply above the lower threshold |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 level |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| lvd_irq | output | 1 | Single-cycle warning interrupt request |
| lvd_rst_req | output | 1 | Active-high internal reset request |

## Verification
The bench builds the block with FILT_CYCLES = 3 and RST_HOLD = 5. Each power-up, warning and reset path therefore completes within a few tens of clocks, and the exact edge counts from R3, R4, R6 and R11 can be checked as small numbers. A filter of 3 also lets a two-cycle comparator glitch sit just below the acceptance length, which tests the filter boundary of R7. The short hold window keeps the re-arm sequence of R6 and the inactive-mode release of R11 short enough to run back to back after several resets.

// File: rtl/lvd_pkg.sv
package lvd_pkg;

  typedef enum logic [1:0] {
    ST_POR   = 2'd0,
    ST_RUN   = 2'd1,
    ST_WARN  = 2'd2,
    ST_LVRST = 2'd3
  } lvd_state_e;

  localparam logic [1:0] MODE_WARN_RESET = 2'b10;

  localparam logic ADDR_CTRL  = 1'b0;
  localparam logic ADDR_LEVEL = 1'b1;

  localparam int CTRL_WEN_BIT  = 7;
  localparam int CTRL_FLAG_BIT = 0;
  localparam int LVL_MODE_BIT  = 7;
  localparam int LVL_SEL_BIT   = 0;

  function automatic logic is_reset_state(input lvd_state_e s);
    return (s == ST_POR) || (s == ST_LVRST);
  endfunction

endpackage

// File: rtl/lvd_input_cond.sv
module lvd_input_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT        = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic clean_out
);

  localparam int             CW   = $clog2(FILT + 1);
  localparam logic [CW-1:0]  LAST = CW'(FILT - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   sync_bit;

  assign sync_bit = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
    end
  end

  // A new level must persist for FILT consecutive clocks before it is taken.
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= '0;
      clean_out <= 1'b0;
    end else if (sync_bit == clean_out) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      clean_out <= sync_bit;
      run_q     <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

endmodule

// File: rtl/lvd_seq.sv
module lvd_seq
  import lvd_pkg::*;
#(
  parameter int HOLD = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       active,
  input  logic       hi_f,
  input  logic       lo_f,
  output lvd_state_e state_q,
  output logic       irq,
  output logic       rst_req
);

  localparam int            HW       = $clog2(HOLD + 1);
  localparam logic [HW-1:0] HOLD_VAL = HW'(HOLD);

  lvd_state_e    state_d;
  logic [HW-1:0] hold_q;

  always_comb begin
    state_d = state_q;
    if (!active) begin
      state_d = ST_RUN;
    end else begin
      unique case (state_q)
        ST_POR:   if (hi_f && lo_f) state_d = ST_RUN;
        ST_RUN: begin
          if (!lo_f)      state_d = ST_LVRST;
          else if (!hi_f) state_d = ST_WARN;
        end
        ST_WARN:  if (!lo_f) state_d = ST_LVRST;
        ST_LVRST: if (hi_f && lo_f) state_d = ST_RUN;
        default:  state_d = ST_POR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_POR;
      irq     <= 1'b0;
    end else begin
      state_q <= state_d;
      irq     <= (state_d == ST_WARN) && (state_q != ST_WARN);
    end
  end

  // Stretch: counter reloads while in a reset state, drains afterwards.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= HOLD_VAL;
      rst_req <= 1'b1;
    end else begin
      if (is_reset_state(state_q)) begin
        hold_q <= HOLD_VAL;
      end else if (hold_q != '0) begin
        hold_q <= hold_q - 1'b1;
      end
      rst_req <= is_reset_state(state_q) || (hold_q != '0);
    end
  end

endmodule

// File: rtl/lvd_regs.sv
module lvd_regs
  import lvd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic       addr,
  input  logic [7:0] wdata,
  input  logic       irq_evt,
  output logic [7:0] rdata
);

  logic wen_q;
  logic flag_q;
  logic lvl_mode_q;
  logic lvl_sel_q;
  logic ctrl_wr;
  logic level_wr;
  logic unused_wbits;

  assign ctrl_wr      = we && (addr == ADDR_CTRL);
  assign level_wr     = we && (addr == ADDR_LEVEL);
  assign unused_wbits = ^wdata[6:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      wen_q      <= 1'b0;
      flag_q     <= 1'b0;
      lvl_mode_q <= 1'b0;
      lvl_sel_q  <= 1'b0;
      rdata      <= '0;
    end else begin
      if (ctrl_wr) wen_q <= wdata[CTRL_WEN_BIT];

      if (irq_evt)                             flag_q <= 1'b1;
      else if (ctrl_wr && wdata[CTRL_FLAG_BIT]) flag_q <= 1'b0;

      if (level_wr && wen_q) begin
        lvl_mode_q <= wdata[LVL_MODE_BIT];
        lvl_sel_q  <= wdata[LVL_SEL_BIT];
      end

      if (addr == ADDR_CTRL) rdata <= {wen_q, 6'b0, flag_q};
      else                   rdata <= {lvl_mode_q, 6'b0, lvl_sel_q};
    end
  end

endmodule

// File: rtl/lvd_supervisor.sv
module lvd_supervisor
  import lvd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 4,
  parameter int RST_HOLD    = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  logic       vdd_above_hi,
  input  logic       vdd_above_lo,
  input  logic       reg_we,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       lvd_irq,
  output logic       lvd_rst_req
);

  localparam int NUM_CMP = 2;

  logic [1:0]         mode_q;
  logic               active;
  logic [NUM_CMP-1:0] cmp_raw;
  logic [NUM_CMP-1:0] cmp_clean;
  lvd_state_e         seq_state;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= mode_sel;
  end

  assign active  = (mode_q == MODE_WARN_RESET);
  assign cmp_raw = {vdd_above_lo, vdd_above_hi};

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    lvd_input_cond #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT       (FILT_CYCLES)
    ) u_cond (
      .clk      (clk),
      .rst      (rst),
      .async_in (cmp_raw[g]),
      .clean_out(cmp_clean[g])
    );
  end

  lvd_seq #(
    .HOLD(RST_HOLD)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .active (active),
    .hi_f   (cmp_clean[0]),
    .lo_f   (cmp_clean[1]),
    .state_q(seq_state),
    .irq    (lvd_irq),
    .rst_req(lvd_rst_req)
  );

  lvd_regs u_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (reg_we),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .irq_evt(lvd_irq),
    .rdata  (reg_rdata)
  );

endmodule

// File: rtl/lvd_supervisor_chk.sv
module lvd_seq_chk
  import lvd_pkg::*;
#(
  parameter int HOLD = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       active,
  input lvd_state_e state_q,
  input logic       irq,
  input logic       rst_req
);

  logic [15:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst)                          run_cnt <= '0;
    else if (is_reset_state(state_q)) run_cnt <= '0;
    else if (run_cnt != 16'hFFFF)     run_cnt <= run_cnt + 1'b1;
  end

  a_r4_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  a_r3_stretch_min: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_req) |-> (32'(run_cnt) >= HOLD));

  a_r2_por_held: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> rst_req);

  a_r5_warn_silent: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_WARN) && ($past(state_q) == ST_WARN)) |-> !irq);

  a_r6_lv_reset: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LVRST) |=> rst_req);

  a_r11_inactive_quiet: assert property (@(posedge clk) disable iff (rst)
    !active |-> !irq);

endmodule

module lvd_regs_chk (
  input logic clk,
  input logic rst,
  input logic we,
  input logic addr,
  input logic wr_bit0,
  input logic irq_evt,
  input logic wen_q,
  input logic flag_q,
  input logic lvl_mode_q,
  input logic lvl_sel_q
);

  a_r9_level_locked: assert property (@(posedge clk) disable iff (rst)
    (we && addr && !wen_q) |=> $stable({lvl_mode_q, lvl_sel_q}));

  a_r10_flag_set: assert property (@(posedge clk) disable iff (rst)
    irq_evt |=> flag_q);

  a_r10_flag_keep: assert property (@(posedge clk) disable iff (rst)
    (!irq_evt && !(we && !addr && wr_bit0)) |=> $stable(flag_q));

endmodule

bind lvd_seq lvd_seq_chk #(.HOLD(HOLD)) u_seq_chk (
  .clk    (clk),
  .rst    (rst),
  .active (active),
  .state_q(state_q),
  .irq    (irq),
  .rst_req(rst_req)
);

bind lvd_regs lvd_regs_chk u_regs_chk (
  .clk       (clk),
  .rst       (rst),
  .we        (we),
  .addr      (addr),
  .wr_bit0   (wdata[0]),
  .irq_evt   (irq_evt),
  .wen_q     (wen_q),
  .flag_q    (flag_q),
  .lvl_mode_q(lvl_mode_q),
  .lvl_sel_q (lvl_sel_q)
);

// File: tb/sim_lvd_supervisor.sv
`timescale 1ns/1ps
module sim_lvd_supervisor;

  localparam int FILT = 3;
  localparam int HOLD = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_sel = 2'b10;
  logic       hi = 1'b0;
  logic       lo = 1'b0;
  logic       reg_we = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       lvd_irq;
  logic       lvd_rst_req;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lvd_supervisor #(
    .SYNC_STAGES(2),
    .FILT_CYCLES(FILT),
    .RST_HOLD   (HOLD)
  ) u0 (
    .clk         (clk),
    .rst         (rst),
    .mode_sel    (mode_sel),
    .vdd_above_hi(hi),
    .vdd_above_lo(lo),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .lvd_irq     (lvd_irq),
    .lvd_rst_req (lvd_rst_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst = 1'b1; mode_sel = m; hi = 1'b0; lo = 1'b0; reg_we = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(lvd_rst_req == 1'b1, "R2 rst_req during reset", int'(lvd_rst_req), 1);
    rst = 1'b0;
  endtask

  task automatic reg_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // Counts rising edges until the chosen output equals val (sampled at negedge).
  task automatic wait_out(input bit use_irq, input logic val, output int n);
    n = -1;
    for (int i = 1; i <= 60; i++) begin
      @(posedge clk);
      @(negedge clk);
      if ((use_irq ? lvd_irq : lvd_rst_req) == val) begin
        n = i;
        return;
      end
    end
  endtask

  task automatic t_reset_state;
    logic [7:0] d;
    do_reset(2'b10);
    reg_read(1'b0, d);
    chk(d == 8'h00, "R8 control after reset", int'(d), 0);
    reg_read(1'b1, d);
    chk(d == 8'h00, "R8 level after reset", int'(d), 0);
    repeat (20) @(negedge clk);
    chk(lvd_rst_req == 1'b1, "R2 held with low supply", int'(lvd_rst_req), 1);
    chk(lvd_irq == 1'b0, "R2 no irq at power-up", int'(lvd_irq), 0);
  endtask

  task automatic t_power_up;
    int n;
    @(negedge clk);
    hi = 1'b1; lo = 1'b1;
    wait_out(1'b0, 1'b0, n);
    chk(n == FILT + HOLD + 4, "R3 power-up release edge", n, FILT + HOLD + 4);
  endtask

  task automatic t_warn;
    int n;
    logic [7:0] d;
    @(negedge clk);
    hi = 1'b0;
    wait_out(1'b1, 1'b1, n);
    chk(n == FILT + 3, "R4 irq edge", n, FILT + 3);
    chk(lvd_rst_req == 1'b0, "R4 no reset on warning", int'(lvd_rst_req), 0);
    @(negedge clk);
    chk(lvd_irq == 1'b0, "R4 irq one cycle", int'(lvd_irq), 0);
    reg_read(1'b0, d);
    chk(d == 8'h01, "R10 flag set by irq", int'(d), 1);
  endtask

  task automatic t_no_rewarn;
    int seen = 0;
    int rs = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      hi = 1'b1;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (lvd_irq) seen++;
        if (lvd_rst_req) rs++;
      end
      hi = 1'b0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (lvd_irq) seen++;
        if (lvd_rst_req) rs++;
      end
    end
    chk(seen == 0, "R5 no second irq", seen, 0);
    chk(rs == 0, "R5 no reset while warned", rs, 0);
  endtask

  task automatic t_flag_clear;
    logic [7:0] d;
    reg_write(1'b0, 8'h00);
    reg_read(1'b0, d);
    chk(d == 8'h01, "R10 write 0 keeps flag", int'(d), 1);
    reg_write(1'b0, 8'h01);
    reg_read(1'b0, d);
    chk(d == 8'h00, "R10 write 1 clears flag", int'(d), 0);
  endtask

  task automatic t_glitch;
    int rs = 0;
    @(negedge clk);
    lo = 1'b0;
    @(negedge clk);
    @(negedge clk);
    lo = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (lvd_rst_req) rs++;
    end
    chk(rs == 0, "R7 short low glitch ignored", rs, 0);
  endtask

  task automatic t_lvreset;
    int n;
    @(negedge clk);
    lo = 1'b0;
    wait_out(1'b0, 1'b1, n);
    chk(n == FILT + 4, "R6 reset rise edge", n, FILT + 4);
    @(negedge clk);
    hi = 1'b1; lo = 1'b1;
    wait_out(1'b0, 1'b0, n);
    chk(n == FILT + HOLD + 4, "R6 release edge", n, FILT + HOLD + 4);
    @(negedge clk);
    hi = 1'b0;
    wait_out(1'b1, 1'b1, n);
    chk(n == FILT + 3, "R6 re-armed irq", n, FILT + 3);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    do_reset(2'b10);
    reg_write(1'b1, 8'hFF);
    reg_read(1'b1, d);
    chk(d == 8'h00, "R9 locked write ignored", int'(d), 0);
    reg_write(1'b0, 8'h80);
    reg_read(1'b0, d);
    chk(d == 8'h80, "R12 control readback", int'(d), 8'h80);
    reg_write(1'b1, 8'hFF);
    reg_read(1'b1, d);
    chk(d == 8'h81, "R9 unlocked write bits 7 and 0", int'(d), 8'h81);
    reg_write(1'b1, 8'h80);
    reg_write(1'b0, 8'h00);
    reg_write(1'b1, 8'h01);
    reg_read(1'b1, d);
    chk(d == 8'h80, "R9 relocked write ignored", int'(d), 8'h80);
  endtask

  task automatic t_mode_latch;
    int n;
    do_reset(2'b10);
    @(negedge clk);
    mode_sel = 2'b00;
    hi = 1'b1; lo = 1'b1;
    wait_out(1'b0, 1'b0, n);
    chk(n == FILT + HOLD + 4, "R1 release with latched mode", n, FILT + HOLD + 4);
    @(negedge clk);
    hi = 1'b0;
    wait_out(1'b1, 1'b1, n);
    chk(n == FILT + 3, "R1 mode change after reset ignored", n, FILT + 3);
  endtask

  task automatic t_inactive;
    int n;
    int seen = 0;
    do_reset(2'b01);
    wait_out(1'b0, 1'b0, n);
    chk(n == HOLD + 2, "R11 release in other mode", n, HOLD + 2);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      hi = i[3];
      lo = i[4];
      if (lvd_irq) seen++;
    end
    chk(seen == 0, "R11 no irq in other mode", seen, 0);
    chk(lvd_rst_req == 1'b0, "R11 reset stays low", int'(lvd_rst_req), 0);
  endtask

  bit done = 1'b0;

  initial begin
    t_reset_state();
    t_power_up();
    t_warn();
    t_no_rewarn();
    t_flag_clear();
    t_glitch();
    t_lvreset();
    t_regs();
    t_mode_latch();
    t_inactive();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule